// File: doc/BRIEF.md
# IR Carrier Modulator and Transmit Output

This block decides, interval by interval, whether an infrared transmit pin carries a square-wave carrier or sits at a quiet level. A 16-bit interval counter is loaded with a modulation time and counts down. Each count is either one completed carrier period or one IR clock tick, as chosen by a mode input. When the counter expires, the block starts a new interval at once. At every interval start it captures four things together: the data bit, the polarity bit, and the carrier high and low lengths. The carrier generator lives inside the block, and its settings change only at these sample points. So the duty cycle and frequency can be changed from one interval to the next without glitches inside an interval.

Software feeds the next data bit and time value after each interval. An interval-done strobe tells it when, and a sticky pending flag can raise an interrupt. When the transmitter is disabled or not in transmit mode, the pin simply follows a manual level bit. The IR clock divider that produces `tick_en` is outside the block.

Top module: `irtx_modulator`

## Requirements
- R1: While `tx_enable` or `tx_mode` is 0, `ir_out` equals `manual_level`. Data, polarity and timing inputs have no effect on it.
- R2: On the first clock edge that sees both `tx_enable` and `tx_mode` at 1, an interval starts. From the cycle after that edge, with data 0, `ir_out` equals the polarity bit.
- R3: With sampled data 1, `ir_out` is the carrier XOR the sampled polarity. The carrier starts each interval in its high phase, stays high for `carrier_high`+1 ticks, then stays low for `carrier_low`+1 ticks, and repeats.
- R4: With sampled data 0, `ir_out` holds the sampled polarity bit for the whole interval.
- R5: `data_bit`, `polarity`, `carrier_high` and `carrier_low` are sampled only at interval start. Changes during an interval do not affect `ir_out` until the next interval.
- R6: With `step_by_clock`=1, the counter decrements on each `tick_en`, and an interval lasts `mod_time`+1 ticks.
- R7: With `step_by_clock`=0, the counter decrements once per completed carrier period (the end of a low phase), and an interval lasts `mod_time`+1 carrier periods.
- R8: `carrier_latch` is high in the cycle before each edge that starts an interval, whether that start comes from activation or from expiry. `interval_done` is high for the cycle after each expiry edge and never after an activation edge.
- R9: A pending flag is set by each expiry and cleared by a `done_clear` cycle, with set winning over clear. `irq` = pending AND `irq_enable`.
- R10: After reset, `interval_done` and `irq` are 0 and `ir_out` equals `manual_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle IR clock tick enable |
| tx_enable | input | 1 | Timer enable |
| tx_mode | input | 1 | Transmit mode select |
| step_by_clock | input | 1 | 1: count IR ticks, 0: count carrier periods |
| data_bit | input | 1 | Carrier on (1) or idle (0) for next interval |
| polarity | input | 1 | Idle level and carrier inversion |
| mod_time | input | 16 | Interval length minus one, in counts |
| carrier_high | input | 8 | Carrier high length minus one, in ticks |
| carrier_low | input | 8 | Carrier low length minus one, in ticks |
| manual_level | input | 1 | Pin level while transmit is off |
| irq_enable | input | 1 | Interrupt enable |
| done_clear | input | 1 | Clears the pending flag |
| ir_out | output | 1 | IR transmit pin |
| carrier_latch | output | 1 | Interval-start strobe to the carrier generator |
| interval_done | output | 1 | One-cycle interval expiry strobe |
| irq | output | 1 | Interrupt request |

## Verification
- **`ir_out`, `interval_done`, `irq` (registered):** each is due in the first cycle after the clock edge that causes it. The bench drives inputs on the falling edge and checks these outputs on the falling edge that follows the causing rising edge.
- **`carrier_latch` (combinational):** it is checked in the same half-cycle as the counter state that produces it.
- **Interval and carrier timing:** these are checked by numbering the falling edges after the activation edge, starting from k=0. In clock mode, done pulses are expected at multiples of `mod_time`+1. In carrier mode, they are expected at multiples of the carrier period times (`mod_time`+1), and the carrier level is predicted from k.

// File: rtl/irtx_pkg.sv
// Package: shared widths and types for the IR transmit modulator.
// Assumes: all users take widths from here unless overridden per instance.
package irtx_pkg;
    localparam int CNT_W_DEF = 16;
    localparam int HI_W_DEF  = 8;
    localparam int LO_W_DEF  = 8;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } carrier_phase_e;
endpackage

// File: rtl/irtx_carrier_gen.sv
// Module: carrier generator.
// Produces a square wave: high for hi_len+1 advances, then low for lo_len+1
// advances. The lengths are captured on 'load', which also restarts the wave
// in its high phase. 'wrap' marks the advance that completes a full period.
// Assumes: 'advance' is already qualified by the IR tick and the run state.
module irtx_carrier_gen
    import irtx_pkg::*;
#(
    parameter int HI_W = HI_W_DEF,
    parameter int LO_W = LO_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            advance,
    input  logic [HI_W-1:0] hi_len_in,
    input  logic [LO_W-1:0] lo_len_in,
    output logic            level,
    output logic            wrap
);
    localparam int CW = (HI_W > LO_W) ? HI_W : LO_W;

    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;
    logic [CW-1:0]   cnt_q;
    carrier_phase_e  phase_q;

    logic hi_last, lo_last;

    // Phase end detection against the captured lengths.
    always_comb begin
        hi_last = (cnt_q == CW'(hi_q));
        lo_last = (cnt_q == CW'(lo_q));
    end

    assign level = (phase_q == PH_HIGH);
    assign wrap  = advance && (phase_q == PH_LOW) && lo_last;

    // Captures lengths on load, otherwise steps the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            cnt_q   <= '0;
            phase_q <= PH_HIGH;
        end else if (load) begin
            hi_q    <= hi_len_in;
            lo_q    <= lo_len_in;
            cnt_q   <= '0;
            phase_q <= PH_HIGH;
        end else if (advance) begin
            if (phase_q == PH_HIGH) begin
                if (hi_last) begin
                    phase_q <= PH_LOW;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                if (lo_last) begin
                    phase_q <= PH_HIGH;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irtx_interval_ctr.sv
// Module: interval down counter.
// Loads load_val on 'load' and decrements on each 'step' until it reaches zero.
// 'expire' flags a step taken while the count is already zero. That step ends
// the interval, so an interval spans load_val+1 steps.
// Assumes: the owner feeds 'expire' back into 'load' to restart at once.
module irtx_interval_ctr
    import irtx_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    // Zero detect on the live count.
    always_comb at_zero = (cnt_q == '0);

    assign expire = run && step && at_zero;

    // Reloads at interval start, else counts toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && step && !at_zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/irtx_out_stage.sv
// Module: output stage.
// Captures the data and polarity bits at interval start, then selects the
// pin level. While running: carrier XOR polarity when data is 1, polarity
// when data is 0. While not running: the manual level.
// Assumes: 'run' is the registered active state of the transmitter.
module irtx_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    input  logic data_in,
    input  logic pol_in,
    input  logic carrier_lvl,
    input  logic manual_level,
    output logic data_q,
    output logic pol_q,
    output logic ir_out
);
    // Interval-start sampling of the data and polarity bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 1'b0;
            pol_q  <= 1'b0;
        end else if (load) begin
            data_q <= data_in;
            pol_q  <= pol_in;
        end
    end

    // Pin level selection.
    always_comb begin
        if (!run)        ir_out = manual_level;
        else if (data_q) ir_out = carrier_lvl ^ pol_q;
        else             ir_out = pol_q;
    end
endmodule

// File: rtl/irtx_modulator.sv
// Module: IR carrier modulator and transmit output (top).
// Runs back-to-back intervals while enabled and in transmit mode. Each
// interval start samples data, polarity and carrier lengths together. Counts
// are IR ticks or completed carrier periods. Expiry pulses interval_done and
// sets a sticky pending flag that feeds irq.
// Assumes: tick_en is a clean single-cycle enable from an external divider.
module irtx_modulator
    import irtx_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int HI_W  = HI_W_DEF,
    parameter int LO_W  = LO_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             tx_enable,
    input  logic             tx_mode,
    input  logic             step_by_clock,
    input  logic             data_bit,
    input  logic             polarity,
    input  logic [CNT_W-1:0] mod_time,
    input  logic [HI_W-1:0]  carrier_high,
    input  logic [LO_W-1:0]  carrier_low,
    input  logic             manual_level,
    input  logic             irq_enable,
    input  logic             done_clear,
    output logic             ir_out,
    output logic             carrier_latch,
    output logic             interval_done,
    output logic             irq
);
    logic active_req;
    logic active_q;
    logic start_now;
    logic end_now;
    logic step;
    logic car_level;
    logic car_wrap;
    logic advance;
    logic sampled_data;
    logic sampled_pol;
    logic pending_q;
    logic done_q;

    // Activation request and derived strobes.
    always_comb begin
        active_req = tx_enable && tx_mode;
        start_now  = active_req && !active_q;
        advance    = active_q && tick_en;
        step       = step_by_clock ? tick_en : car_wrap;
    end

    assign carrier_latch = start_now || end_now;

    // Registered run state.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active_req;
    end

    irtx_carrier_gen #(
        .HI_W(HI_W),
        .LO_W(LO_W)
    ) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (carrier_latch),
        .advance  (advance),
        .hi_len_in(carrier_high),
        .lo_len_in(carrier_low),
        .level    (car_level),
        .wrap     (car_wrap)
    );

    irtx_interval_ctr #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active_q),
        .load    (carrier_latch),
        .step    (step),
        .load_val(mod_time),
        .expire  (end_now)
    );

    irtx_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (carrier_latch),
        .run         (active_q),
        .data_in     (data_bit),
        .pol_in      (polarity),
        .carrier_lvl (car_level),
        .manual_level(manual_level),
        .data_q      (sampled_data),
        .pol_q       (sampled_pol),
        .ir_out      (ir_out)
    );

    // Expiry strobe and sticky pending flag; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            done_q <= end_now;
            if (end_now)         pending_q <= 1'b1;
            else if (done_clear) pending_q <= 1'b0;
        end
    end

    assign interval_done = done_q;
    assign irq           = pending_q && irq_enable;
endmodule

// File: rtl/irtx_modulator_chk.sv
// Module: property checker for irtx_modulator, attached by bind.
// Assumes: connected to top-level ports and to the sampled state signals.
module irtx_modulator_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_enable,
    input logic tx_mode,
    input logic manual_level,
    input logic irq_enable,
    input logic ir_out,
    input logic carrier_latch,
    input logic interval_done,
    input logic irq,
    input logic active_q,
    input logic sampled_data,
    input logic sampled_pol
);
    // R1
    manual_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_enable && tx_mode) |-> ir_out == manual_level);

    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q && !sampled_data |-> ir_out == sampled_pol);

    // R5
    hold_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(carrier_latch) |-> $stable(sampled_data) && $stable(sampled_pol));

    // R8
    done_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        interval_done |-> $past(tx_enable && tx_mode));

    // R8
    start_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(carrier_latch));

    // R9
    irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        interval_done && irq_enable |-> irq);
endmodule

bind irtx_modulator irtx_modulator_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_enable    (tx_enable),
    .tx_mode      (tx_mode),
    .manual_level (manual_level),
    .irq_enable   (irq_enable),
    .ir_out       (ir_out),
    .carrier_latch(carrier_latch),
    .interval_done(interval_done),
    .irq          (irq),
    .active_q     (active_q),
    .sampled_data (sampled_data),
    .sampled_pol  (sampled_pol)
);

// File: tb/irtx_modulator_test.sv
module irtx_modulator_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        tx_enable = 1'b0;
    logic        tx_mode = 1'b0;
    logic        step_by_clock = 1'b1;
    logic        data_bit = 1'b0;
    logic        polarity = 1'b0;
    logic [15:0] mod_time = 16'd0;
    logic [7:0]  carrier_high = 8'd0;
    logic [7:0]  carrier_low = 8'd0;
    logic        manual_level = 1'b1;
    logic        irq_enable = 1'b1;
    logic        done_clear = 1'b0;
    logic        ir_out, carrier_latch, interval_done, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irtx_modulator uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tx_enable(tx_enable),
        .tx_mode(tx_mode), .step_by_clock(step_by_clock), .data_bit(data_bit),
        .polarity(polarity), .mod_time(mod_time), .carrier_high(carrier_high),
        .carrier_low(carrier_low), .manual_level(manual_level),
        .irq_enable(irq_enable), .done_clear(done_clear), .ir_out(ir_out),
        .carrier_latch(carrier_latch), .interval_done(interval_done), .irq(irq)
    );

    // Vector fields: {tx_enable, tx_mode, manual_level, polarity, data_bit, expected ir_out}
    localparam logic [5:0] VEC [8] = '{
        6'b000000, 6'b011111, 6'b101011, 6'b100110,
        6'b110000, 6'b111101, 6'b110011, 6'b111110
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        tx_enable = 1'b0;
        tx_mode   = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(ir_out == 1'b1, "R10 ir_out", ir_out, 1);
        chk(interval_done == 1'b0, "R10 interval_done", interval_done, 0);
        chk(irq == 1'b0, "R10 irq", irq, 0);
        rst_n = 1'b1;
        irq_enable = 1'b0;

        // Vector table: static levels on activation (R1, R2, R3)
        foreach (VEC[i]) begin
            go_idle();
            carrier_high = 8'd200;
            carrier_low  = 8'd200;
            mod_time     = 16'd1000;
            step_by_clock = 1'b1;
            {tx_enable, tx_mode, manual_level, polarity, data_bit} = VEC[i][5:1];
            @(negedge clk);
            if (!(VEC[i][5] && VEC[i][4]))
                chk(ir_out == VEC[i][0], "R1 manual level", ir_out, VEC[i][0]);
            else if (VEC[i][1])
                chk(ir_out == VEC[i][0], "R3 inverted carrier", ir_out, VEC[i][0]);
            else
                chk(ir_out == VEC[i][0], "R2 idle on enable", ir_out, VEC[i][0]);
        end

        // R3: carrier shape, high 2 ticks then low 3 ticks
        go_idle();
        manual_level = 1'b0;
        data_bit = 1'b1; polarity = 1'b0;
        carrier_high = 8'd1; carrier_low = 8'd2; mod_time = 16'd1000;
        tx_enable = 1'b1; tx_mode = 1'b1;
        #1 chk(carrier_latch == 1'b1, "R8 latch on activation", carrier_latch, 1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(ir_out == ((k < 2 || k == 5) ? 1'b1 : 1'b0), "R3 carrier shape",
                ir_out, (k < 2 || k == 5) ? 1 : 0);
        end

        // R6: clock mode, interval of mod_time+1 = 5 ticks
        go_idle();
        data_bit = 1'b0; mod_time = 16'd4; step_by_clock = 1'b1;
        tx_enable = 1'b1; tx_mode = 1'b1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            chk(interval_done == (k > 0 && k % 5 == 0), "R6 done spacing",
                interval_done, (k > 0 && k % 5 == 0) ? 1 : 0);
            if (k == 4 || k == 9)
                chk(carrier_latch == 1'b1, "R8 latch at expiry", carrier_latch, 1);
        end

        // R7: carrier mode, period 2 ticks, 3 periods per interval
        go_idle();
        data_bit = 1'b1; polarity = 1'b0;
        carrier_high = 8'd0; carrier_low = 8'd0; mod_time = 16'd2;
        step_by_clock = 1'b0;
        tx_enable = 1'b1; tx_mode = 1'b1;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            chk(interval_done == (k > 0 && k % 6 == 0), "R7 done spacing",
                interval_done, (k > 0 && k % 6 == 0) ? 1 : 0);
            chk(ir_out == (k % 2 == 0), "R7 carrier level", ir_out, (k % 2 == 0) ? 1 : 0);
        end

        // R5: data change mid-interval takes effect only at the next interval
        go_idle();
        data_bit = 1'b0; polarity = 1'b0;
        carrier_high = 8'd100; carrier_low = 8'd100; mod_time = 16'd4;
        step_by_clock = 1'b1;
        tx_enable = 1'b1; tx_mode = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k < 5)
                chk(ir_out == 1'b0, "R4 idle held", ir_out, 0);
            else
                chk(ir_out == 1'b1, "R5 new data at next interval", ir_out, 1);
            if (k == 1) begin
                data_bit = 1'b1;
                carrier_high = 8'd0;
            end
        end

        // R9: sticky flag, interrupt gating and clear
        @(negedge clk);
        tx_enable = 1'b0;
        irq_enable = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        irq_enable = 1'b1;
        #1 chk(irq == 1'b1, "R9 pending flag sticky", irq, 1);
        done_clear = 1'b1;
        @(negedge clk);
        done_clear = 1'b0;
        #1 chk(irq == 1'b0, "R9 cleared", irq, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule